// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Unit

The block watches a small group of asynchronous external interrupt pins. Each pin is brought into the clock domain by a two-stage synchroniser. An edge detector then compares each synchronised sample with the one before it. Every pin has its own polarity bit that selects whether a rising or a falling transition counts, and its own enable bit. A qualifying transition latches a sticky flag for that pin whether or not the pin is enabled. The flag stays latched until software writes a one to the pin's bit in the clear register. Each pin's interrupt request is its flag gated by its enable, and the requests go to a separate priority controller.

The block also produces wake requests for a power manager. In light sleep, a qualifying edge on any pin that was enabled while the system was still running raises a one-cycle wake pulse. In deep sleep, only pin 0 can wake the system. That wake appears on a separate reset-wake output, because the system restarts from reset rather than taking a vectored interrupt. Configuration uses a plain single-cycle write strobe. There is no streaming data path, so no valid/ready handshake applies.

Top module: `ext_irq_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every flag, clears every enable and sets every polarity bit to 1 (rising).
- R2: Only transitions are detected, never levels. With polarity bit 1 a 0→1 transition qualifies; with polarity bit 0 a 1→0 transition qualifies. The opposite transition and a held level never set a flag.
- R3: A qualifying edge sets the pin's flag even when the pin's enable bit is 0.
- R4: A set flag stays set until a write to address 2 with a 1 in that pin's bit position of `wr_data`. Bits written as 0 leave their flags unchanged. Writes to address 0 set the enables, writes to address 1 set the polarity bits, and address 3 is ignored.
- R5: `irq_o[i]` is high exactly when flag i is set and enable bit i is 1.
- R6: A pin change that is stable before clock edge k appears on `flag_o` after edge k+2 and not before.
- R7: A write to address 1 that changes a pin's polarity bit suppresses that pin's detection for the one cycle after the write. Edge tracking is not reset, so no later false flag arises from the change.
- R8: When a clear and a new qualifying edge reach the same flag in the same cycle, the flag stays set.
- R9: In light sleep (`pwr_state` = 1), `wake_o` pulses for one cycle, in the cycle the flag sets, for an edge on a pin whose enable was 1 in the last running cycle. Enables written during sleep do not count toward wake.
- R10: In deep sleep (`pwr_state` = 2), only a pin 0 edge can wake, and only if enable 0 was 1 before entry. It pulses `rst_wake_o` for one cycle, and `wake_o` stays 0.
- R11: In the running state (`pwr_state` = 0, and also code 3), neither `wake_o` nor `rst_wake_o` asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | NPINS | Asynchronous external interrupt pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 enable, 1 polarity, 2 write-one-to-clear flags, 3 ignored |
| wr_data | input | NPINS | Write data, one bit per pin |
| pwr_state | input | 2 | 0 run, 1 light sleep, 2 deep sleep, 3 treated as run |
| flag_o | output | NPINS | Sticky edge flags |
| irq_o | output | NPINS | Per-pin requests, flag and enable |
| wake_o | output | 1 | Light-sleep wake pulse |
| rst_wake_o | output | 1 | Deep-sleep wake-by-reset pulse |

## Verification
A wrong previous-sample or synchroniser state appears on `flag_o` within three clock edges as a missing, early or spurious flag. A polarity mix-up shows on the very next transition of the affected pin. A corrupted copy of the enables captured at sleep entry appears only as a missing or extra `wake_o` or `rst_wake_o` pulse during the next edge in sleep. For that reason the bench compares all outputs against its model on every cycle and drives edges both on pins enabled before sleep entry and on pins enabled only during sleep.

// File: rtl/eiu_pkg.sv
package eiu_pkg;
  typedef enum logic [1:0] {
    PWR_RUN   = 2'd0,
    PWR_LIGHT = 2'd1,
    PWR_DEEP  = 2'd2,
    PWR_RSVD  = 2'd3
  } pwr_t;

  localparam logic [1:0] ADDR_ENABLE = 2'd0;
  localparam logic [1:0] ADDR_POLAR  = 2'd1;
  localparam logic [1:0] ADDR_CLEAR  = 2'd2;
endpackage

// File: rtl/eiu_sync.sv
module eiu_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign sync_o = chain[LAST];

  initial begin
    assert (STAGES >= 2) else $error("eiu_sync needs at least two stages");
  end
endmodule

// File: rtl/eiu_edge.sv
module eiu_edge #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] smp_i,
  input  logic [W-1:0] polar_i,
  input  logic [W-1:0] hold_i,
  output logic [W-1:0] det_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= smp_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall;
    assign rise     = smp_i[i] & ~prev_q[i];
    assign fall     = ~smp_i[i] & prev_q[i];
    assign det_o[i] = ~hold_i[i] & (polar_i[i] ? rise : fall);

    // R2: a detection needs the sample to differ from the previous one
    p_edge_only_r2: assert property (@(posedge clk) disable iff (rst)
      det_o[i] |-> (smp_i[i] != prev_q[i]));
  end
endmodule

// File: rtl/eiu_flags.sv
module eiu_flags #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] det_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (flag_q & ~clr_i) | det_i;
  end

  assign flag_o = flag_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    p_edge_sets_r3: assert property (@(posedge clk) disable iff (rst)
      det_i[i] |=> flag_q[i]);
    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
      (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
      (clr_i[i] && !det_i[i]) |=> !flag_q[i]);
  end
endmodule

// File: rtl/eiu_wake.sv
module eiu_wake #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   pwr_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] det_i,
  output logic         wake_o,
  output logic         rst_wake_o
);
  import eiu_pkg::*;

  logic [W-1:0] armed_q;
  logic         wake_q, rwake_q;
  logic         light, deep;

  assign light = (pwr_i == PWR_LIGHT);
  assign deep  = (pwr_i == PWR_DEEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= '0;
      wake_q  <= 1'b0;
      rwake_q <= 1'b0;
    end else begin
      if (!light && !deep) armed_q <= en_i;
      wake_q  <= light & |(det_i & armed_q);
      rwake_q <= deep & det_i[0] & armed_q[0];
    end
  end

  assign wake_o     = wake_q;
  assign rst_wake_o = rwake_q;

  p_run_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (!light && !deep) |=> (!wake_o && !rst_wake_o));
  p_deep_no_vector_r10: assert property (@(posedge clk) disable iff (rst)
    deep |=> !wake_o);
  p_wake_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> !rst_wake_o);
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit #(
  parameter int NPINS       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_i,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [NPINS-1:0] wr_data,
  input  logic [1:0]       pwr_state,
  output logic [NPINS-1:0] flag_o,
  output logic [NPINS-1:0] irq_o,
  output logic             wake_o,
  output logic             rst_wake_o
);
  import eiu_pkg::*;

  logic [NPINS-1:0] en_q, polar_q, hold_q;
  logic [NPINS-1:0] smp, det, clr, flags;
  logic             wr_en_reg, wr_pol_reg, wr_clr_reg;

  assign wr_en_reg  = wr_en && (wr_addr == ADDR_ENABLE);
  assign wr_pol_reg = wr_en && (wr_addr == ADDR_POLAR);
  assign wr_clr_reg = wr_en && (wr_addr == ADDR_CLEAR);
  assign clr        = wr_clr_reg ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      polar_q <= '1;
      hold_q  <= '0;
    end else begin
      if (wr_en_reg)  en_q    <= wr_data;
      if (wr_pol_reg) polar_q <= wr_data;
      hold_q <= wr_pol_reg ? (wr_data ^ polar_q) : '0;
    end
  end

  eiu_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(pin_i), .sync_o(smp)
  );

  eiu_edge #(.W(NPINS)) u_edge (
    .clk(clk), .rst(rst), .smp_i(smp), .polar_i(polar_q),
    .hold_i(hold_q), .det_o(det)
  );

  eiu_flags #(.W(NPINS)) u_flags (
    .clk(clk), .rst(rst), .det_i(det), .clr_i(clr), .flag_o(flags)
  );

  eiu_wake #(.W(NPINS)) u_wake (
    .clk(clk), .rst(rst), .pwr_i(pwr_state), .en_i(en_q), .det_i(det),
    .wake_o(wake_o), .rst_wake_o(rst_wake_o)
  );

  assign flag_o = flags;
  assign irq_o  = flags & en_q;

  // R7: a changed polarity bit blocks that pin for the following cycle
  for (genvar i = 0; i < NPINS; i++) begin : g_hold_chk
    p_polar_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_pol_reg && (wr_data[i] != polar_q[i])) |=> !det[i]);
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (flag_o == '0 && irq_o == '0));
endmodule

// File: tb/tb_ext_irq_unit.sv
module tb_ext_irq_unit;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] pin_i = '0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [N-1:0] wr_data = '0;
  logic [1:0]   pwr_state = 2'd0;
  logic [N-1:0] flag_o, irq_o;
  logic         wake_o, rst_wake_o;

  int tests = 0;
  int fails = 0;
  int wake_cnt = 0;
  int rwake_cnt = 0;

  always #5 clk = ~clk;

  ext_irq_unit #(.NPINS(N), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .pin_i(pin_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwr_state(pwr_state), .flag_o(flag_o), .irq_o(irq_o),
    .wake_o(wake_o), .rst_wake_o(rst_wake_o)
  );

  // behavioural reference: pin history, config and flags as plain integers
  bit m_p1 [N], m_p2 [N], m_p3 [N];
  bit m_flag [N], m_en [N], m_pol [N], m_hold [N], m_arm [N];
  bit m_wake, m_rwake;

  always @(posedge clk) begin
    bit d [N];
    bit any;
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_p1[i] = 0; m_p2[i] = 0; m_p3[i] = 0; m_flag[i] = 0;
        m_en[i] = 0; m_pol[i] = 1; m_hold[i] = 0; m_arm[i] = 0;
      end
      m_wake = 0; m_rwake = 0;
    end else begin
      any = 0;
      for (int i = 0; i < N; i++) begin
        if (m_hold[i]) d[i] = 0;
        else if (m_pol[i]) d[i] = (m_p2[i] == 1 && m_p3[i] == 0);
        else d[i] = (m_p2[i] == 0 && m_p3[i] == 1);
        if (d[i] && m_arm[i]) any = 1;
      end
      m_wake  = (pwr_state == 2'd1) && any;
      m_rwake = (pwr_state == 2'd2) && d[0] && m_arm[0];
      for (int i = 0; i < N; i++) begin
        if (wr_en && wr_addr == 2'd2 && wr_data[i]) m_flag[i] = 0;
        if (d[i]) m_flag[i] = 1;
        if (pwr_state == 2'd0 || pwr_state == 2'd3) m_arm[i] = m_en[i];
        m_hold[i] = (wr_en && wr_addr == 2'd1) ? (wr_data[i] != m_pol[i]) : 0;
        if (wr_en && wr_addr == 2'd0) m_en[i] = wr_data[i];
        if (wr_en && wr_addr == 2'd1) m_pol[i] = wr_data[i];
        m_p3[i] = m_p2[i]; m_p2[i] = m_p1[i]; m_p1[i] = pin_i[i];
      end
    end
  end

  // every-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < N; i++) begin
        tests++;
        if (flag_o[i] !== m_flag[i]) begin
          fails++;
          $display("FAIL R4 flag[%0d] actual %0b expected %0b", i, flag_o[i], m_flag[i]);
        end
        tests++;
        if (irq_o[i] !== (m_flag[i] & m_en[i])) begin
          fails++;
          $display("FAIL R5 irq[%0d] actual %0b expected %0b", i, irq_o[i], m_flag[i] & m_en[i]);
        end
      end
      tests++;
      if (wake_o !== m_wake) begin
        fails++;
        $display("FAIL R9 wake actual %0b expected %0b", wake_o, m_wake);
      end
      tests++;
      if (rst_wake_o !== m_rwake) begin
        fails++;
        $display("FAIL R10 rst_wake actual %0b expected %0b", rst_wake_o, m_rwake);
      end
      if (wake_o === 1'b1) wake_cnt++;
      if (rst_wake_o === 1'b1) rwake_cnt++;
    end
  end

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic pulse(input int i);
    pin_i[i] = 1'b1; cyc(5);
    pin_i[i] = 1'b0; cyc(5);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    chk("R1 flags after reset", flag_o, 4'h0);
    chk("R1 irq after reset", irq_o, 4'h0);

    // R6 latency of a rising edge under the reset-default polarity
    pin_i[0] = 1'b1;
    cyc(2);
    chk("R6 flag not yet after two edges", flag_o, 4'h0);
    cyc(1);
    chk("R6 R1 rising flag after three edges", flag_o, 4'h1);
    chk("R3 flag set while disabled, irq low", irq_o, 4'h0);
    pin_i[0] = 1'b0; cyc(5);
    chk("R2 held level and falling edge add nothing", flag_o, 4'h1);

    // R4 partial clear and ignored address
    pin_i[1] = 1'b1; cyc(5);
    wr(2'd3, 4'hF); cyc(1);
    chk("R4 address 3 ignored", flag_o, 4'h3);
    wr(2'd2, 4'h1); cyc(1);
    chk("R4 clear bit0 only", flag_o, 4'h2);
    wr(2'd2, 4'h2); cyc(1);
    chk("R4 clear bit1", flag_o, 4'h0);
    pin_i[1] = 1'b0; cyc(5);
    chk("R2 falling ignored with polarity 1", flag_o, 4'h0);

    // R2 falling polarity
    wr(2'd1, 4'b1101); cyc(2);
    pin_i[1] = 1'b1; cyc(5);
    chk("R2 rising ignored with polarity 0", flag_o, 4'h0);
    pin_i[1] = 1'b0; cyc(5);
    chk("R2 falling detected with polarity 0", flag_o, 4'h2);

    // R5 irq gating
    wr(2'd0, 4'b0010); cyc(1);
    chk("R5 irq follows enable", irq_o, 4'h2);
    wr(2'd0, 4'b0000); cyc(1);
    chk("R5 irq drops with enable, flag kept", {irq_o[3:2], flag_o[1:0]}, 4'h2);
    wr(2'd2, 4'hF); cyc(1);

    // R7 polarity write lands in the detect cycle and blocks it
    wr(2'd1, 4'b1001); cyc(3);
    pin_i[2] = 1'b1;
    @(negedge clk);
    wr(2'd1, 4'b1101);
    cyc(6);
    chk("R7 no flag from edge during hold cycle", flag_o, 4'h0);
    pin_i[2] = 1'b0; cyc(6);
    chk("R7 no false flag after polarity change", flag_o, 4'h0);

    // R8 clear and edge in the same cycle
    pin_i[3] = 1'b1; cyc(5);
    pin_i[3] = 1'b0; cyc(5);
    chk("R8 setup flag3", flag_o, 4'h8);
    pin_i[3] = 1'b1;
    cyc(2);
    wr(2'd2, 4'h8);
    chk("R8 edge wins over clear", flag_o, 4'h8);
    pin_i[3] = 1'b0; cyc(5);
    wr(2'd2, 4'hF); cyc(1);

    // R9 light sleep wake uses enables from before entry
    wr(2'd0, 4'b0011); cyc(2);
    pwr_state = 2'd1; cyc(2);
    wr(2'd0, 4'b1111); cyc(2);
    wake_cnt = 0;
    pulse(3);
    chk("R9 pin enabled only in sleep gives no wake", wake_cnt[N-1:0], 4'd0);
    chk("R3 flag still set in sleep", flag_o, 4'h8);
    pulse(1);
    chk("R9 armed pin gives one wake pulse", wake_cnt[N-1:0], 4'd1);

    // R10 deep sleep
    pwr_state = 2'd0; cyc(2);
    pwr_state = 2'd2; cyc(2);
    wake_cnt = 0; rwake_cnt = 0;
    pulse(1);
    chk("R10 pin1 cannot wake deep sleep", rwake_cnt[N-1:0], 4'd0);
    pulse(0);
    chk("R10 pin0 gives one reset wake", rwake_cnt[N-1:0], 4'd1);
    chk("R10 no vectored wake in deep sleep", wake_cnt[N-1:0], 4'd0);

    // R11 running state
    pwr_state = 2'd0; cyc(2);
    wake_cnt = 0; rwake_cnt = 0;
    pulse(0); pulse(1);
    pwr_state = 2'd3; cyc(2);
    pulse(2);
    chk("R11 no wake pulses while running", wake_cnt[N-1:0] | rwake_cnt[N-1:0], 4'd0);

    // R1 reset mid-run restores defaults
    rst = 1'b1; cyc(2); rst = 1'b0; cyc(1);
    chk("R1 flags cleared by reset", flag_o, 4'h0);
    pin_i[1] = 1'b1; cyc(5);
    chk("R1 polarity back to rising", flag_o, 4'h2);
    pin_i[1] = 1'b0; cyc(5);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule